// File: doc/BRIEF.md
# Piecewise-Linear Table Interpolator

This unit evaluates a function that is stored as a short table of unsigned samples taken at evenly spaced points. A 16-bit fixed-point argument selects a pair of neighbouring samples through its upper byte. Its lower byte gives the position between them as a fraction of 1/256. The unit then blends the two samples linearly. Samples can be 8, 16 or 32 bits wide. The result comes back either at the sample's own scale, rounded, or unrounded and scaled up by 256 so that no fractional bits are lost.

There are two ways to supply the samples. In memory mode the unit computes a byte address from a base and the argument. It then issues two reads, one after the other, on a synchronous read port that has a latency of one cycle. In operand mode the caller places the two samples on input ports and no memory access happens. Each job begins with a single-cycle start pulse and ends with a single-cycle done pulse.

Top module: `pwl_interp`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, busy, done, mem_rd_en and result are all zero.
- R2: In memory mode the entry size code is 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes. The unit reads exactly twice, on consecutive cycles. The first read is at base_addr + x_in[15:8] × size in bytes and the second is at that address + size in bytes. Read data is taken one cycle after its read enable.
- R3: When round_en = 1, the result is floor((E0×256 + (E1−E0)×f + 128) / 256). Here E0 is the entry at the index, E1 is the following entry and f = x_in[7:0]. This covers decreasing tables, and exact halves round toward positive infinity.
- R4: When round_en = 0, the result is E0×256 + (E1−E0)×f on the 40-bit output, with no division.
- R5: When f = 0, the result is exactly E0 in rounded form and exactly E0×256 in unrounded form.
- R6: In operand mode (mode_reg = 1), E0 is taken from entry_a and E1 from entry_b, and no memory read is issued.
- R7: Entries are unsigned. Bits of mem_rdata, entry_a or entry_b above the selected entry size have no effect on the result.
- R8: done is high for exactly one cycle. It appears 2 cycles after the start cycle in operand mode and 5 cycles after it in memory mode, and busy is low while done is high.
- R9: A start pulse that arrives while busy is high is ignored. The result then holds its value until the next done.
- R10: The inputs are sampled only in the cycle in which start is accepted. Later changes to them do not affect the job in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a job when idle |
| mode_reg | input | 1 | 1 = operand mode, 0 = memory mode |
| round_en | input | 1 | 1 = rounded result, 0 = unrounded ×256 result |
| entry_size | input | 2 | 0 byte, 1 word, 2 long |
| x_in | input | 16 | 8.8 fixed-point argument |
| base_addr | input | ADDR_W | Byte address of table entry 0 |
| entry_a | input | DATA_W | Lower entry in operand mode |
| entry_b | input | DATA_W | Upper entry in operand mode |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Byte address of the entry being read |
| mem_size | output | 2 | Size code of the entry being read |
| mem_rdata | input | DATA_W | Entry value, right-aligned, one cycle after the strobe |
| busy | output | 1 | A job is in progress |
| done | output | 1 | Single-cycle result-valid pulse |
| result | output | DATA_W+8 | Interpolated value |

## Verification
The hardest case to reach from the ports is a start pulse that lands while a memory job is between its two reads. In the same window the argument, base and operands must change, so that a fault that resamples them shows up. In some jobs the bench therefore raises start again one cycle after the accepted pulse and scrambles every input at the same time. It then checks that the read addresses, the latency and the result all match the inputs sampled at the first pulse. Rounding ties and negative slopes seldom appear under random data. Directed jobs therefore force exact halves, a fraction of zero and the largest 32-bit drop.

// File: rtl/pwl_pkg.sv
// Shared types and helpers for the piecewise-linear interpolator.
// Assumes entry sizes are powers of two bytes: 1, 2 or 4.
package pwl_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } esize_t;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RD0  = 3'd1,
        ST_RD1  = 3'd2,
        ST_WAIT = 3'd3,
        ST_CALC = 3'd4
    } pstate_t;

    // log2 of the entry size in bytes; the reserved code acts as long
    function automatic logic [1:0] size_shift(input logic [1:0] code);
        return (code == SZ_BYTE) ? 2'd0 : (code == SZ_WORD) ? 2'd1 : 2'd2;
    endfunction

endpackage

// File: rtl/pwl_seq.sv
// Job sequencer: accepts start when idle, latches the job controls,
// forms the two byte addresses and steps through the memory reads.
// Assumes memory data is valid exactly one cycle after mem_rd_en.
module pwl_seq
    import pwl_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 8,
    parameter int FRAC_W = 8,
    localparam int X_W   = IDX_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode_reg,
    input  logic              round_en,
    input  logic [1:0]        entry_size,
    input  logic [X_W-1:0]    x_in,
    input  logic [ADDR_W-1:0] base_addr,
    output logic              busy,
    output logic              accept,
    output logic              load_ops,
    output logic              cap_lo,
    output logic              cap_hi,
    output logic              calc,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        size_q,
    output logic              round_q,
    output logic [FRAC_W-1:0] frac_q
);

    pstate_t           state;
    pstate_t           state_nx;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] first_addr;
    logic [ADDR_W-1:0] step;

    // byte offset of the indexed entry plus base, and the per-entry stride
    always_comb begin
        first_addr = base_addr + (ADDR_W'(x_in[X_W-1:FRAC_W]) << size_shift(entry_size));
        step       = ADDR_W'(1) << size_shift(size_q);
    end

    assign busy     = (state != ST_IDLE);
    assign accept   = (state == ST_IDLE) && start;
    assign load_ops = accept && mode_reg;
    assign cap_lo   = (state == ST_RD1);
    assign cap_hi   = (state == ST_WAIT);
    assign calc     = (state == ST_CALC);
    assign mem_rd_en = (state == ST_RD0) || (state == ST_RD1);
    assign mem_addr  = addr_q;

    // next-state selection for the job sequence
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: if (start) state_nx = mode_reg ? ST_CALC : ST_RD0;
            ST_RD0:  state_nx = ST_RD1;
            ST_RD1:  state_nx = ST_WAIT;
            ST_WAIT: state_nx = ST_CALC;
            ST_CALC: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register and job-control latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            addr_q  <= '0;
            size_q  <= SZ_BYTE;
            round_q <= 1'b0;
            frac_q  <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                addr_q  <= first_addr;
                size_q  <= entry_size;
                round_q <= round_en;
                frac_q  <= x_in[FRAC_W-1:0];
            end else if (state == ST_RD0) begin
                addr_q <= addr_q + step;
            end
        end
    end

endmodule

// File: rtl/pwl_arith.sv
// Combinational interpolation: forms E0*2^F + (E1-E0)*f, and optionally
// rounds it back to entry scale by adding half an LSB and shifting.
// Assumes E0 and E1 are already zero-extended unsigned entries.
module pwl_arith #(
    parameter int DATA_W = 32,
    parameter int FRAC_W = 8,
    localparam int RES_W = DATA_W + FRAC_W,
    localparam int DIF_W = DATA_W + 1,
    localparam int PRD_W = DIF_W + FRAC_W + 1,
    localparam int SUM_W = PRD_W + 1
) (
    input  logic [DATA_W-1:0] e_lo,
    input  logic [DATA_W-1:0] e_hi,
    input  logic [FRAC_W-1:0] frac,
    input  logic              round_en,
    output logic [RES_W-1:0]  value
);

    localparam logic signed [SUM_W-1:0] HALF = SUM_W'(1) <<< (FRAC_W - 1);

    logic signed [DIF_W-1:0] slope;
    logic signed [PRD_W-1:0] scaled;
    logic signed [SUM_W-1:0] full;
    logic signed [SUM_W-1:0] biased;
    logic signed [SUM_W-1:0] shifted;
    logic                    unused_bits;

    // signed slope, scaled slope, and the two result forms
    always_comb begin
        slope   = $signed({1'b0, e_hi}) - $signed({1'b0, e_lo});
        scaled  = slope * $signed({1'b0, frac});
        full    = $signed({3'b000, e_lo, {FRAC_W{1'b0}}}) + $signed({scaled[PRD_W-1], scaled});
        biased  = full + HALF;
        shifted = biased >>> FRAC_W;
        value   = round_en ? {{FRAC_W{1'b0}}, shifted[DATA_W-1:0]} : full[RES_W-1:0];
    end

    assign unused_bits = ^{full[SUM_W-1:RES_W], shifted[SUM_W-1:DATA_W]};

endmodule

// File: rtl/pwl_interp.sv
// Top of the piecewise-linear interpolator. Holds the two entry
// registers, the result register and the done pulse; the sequencer
// drives the memory port and the arithmetic unit forms the value.
// Assumes mem_rdata carries the entry right-aligned, upper bits don't-care.
module pwl_interp
    import pwl_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8,
    parameter int FRAC_W = 8,
    localparam int X_W   = IDX_W + FRAC_W,
    localparam int RES_W = DATA_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode_reg,
    input  logic              round_en,
    input  logic [1:0]        entry_size,
    input  logic [X_W-1:0]    x_in,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [DATA_W-1:0] entry_a,
    input  logic [DATA_W-1:0] entry_b,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [RES_W-1:0]  result
);

    logic              accept;
    logic              load_ops;
    logic              cap_lo;
    logic              cap_hi;
    logic              calc;
    logic [1:0]        size_q;
    logic              round_q;
    logic [FRAC_W-1:0] frac_q;
    logic [DATA_W-1:0] e_lo_q;
    logic [DATA_W-1:0] e_hi_q;
    logic [RES_W-1:0]  value;
    logic              unused_acc;

    // keep only the bits that belong to the selected entry size
    function automatic logic [DATA_W-1:0] trim(input logic [DATA_W-1:0] v, input logic [1:0] code);
        logic [DATA_W-1:0] m;
        m = ~DATA_W'(0);
        if (code == SZ_BYTE)      m = DATA_W'(8'hFF);
        else if (code == SZ_WORD) m = DATA_W'(16'hFFFF);
        return v & m;
    endfunction

    pwl_seq #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .FRAC_W(FRAC_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_reg(mode_reg),
        .round_en(round_en), .entry_size(entry_size), .x_in(x_in),
        .base_addr(base_addr), .busy(busy), .accept(accept),
        .load_ops(load_ops), .cap_lo(cap_lo), .cap_hi(cap_hi), .calc(calc),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .size_q(size_q),
        .round_q(round_q), .frac_q(frac_q)
    );

    pwl_arith #(
        .DATA_W(DATA_W), .FRAC_W(FRAC_W)
    ) u_arith (
        .e_lo(e_lo_q), .e_hi(e_hi_q), .frac(frac_q),
        .round_en(round_q), .value(value)
    );

    assign mem_size   = size_q;
    assign unused_acc = accept;

    // entry registers: loaded from operands at start or from memory reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_lo_q <= '0;
            e_hi_q <= '0;
        end else if (load_ops) begin
            e_lo_q <= trim(entry_a, entry_size);
            e_hi_q <= trim(entry_b, entry_size);
        end else begin
            if (cap_lo) e_lo_q <= trim(mem_rdata, size_q);
            if (cap_hi) e_hi_q <= trim(mem_rdata, size_q);
        end
    end

    // result register and single-cycle completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= calc;
            if (calc) result <= value;
        end
    end

endmodule

// File: rtl/pwl_interp_chk.sv
// Protocol checker for pwl_interp, attached by bind. Observes ports only.
module pwl_interp_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              mode_reg,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [1:0]        mem_size,
    input logic              busy,
    input logic              done
);

    function automatic logic [ADDR_W-1:0] stride(input logic [1:0] code);
        return (code == 2'd0) ? ADDR_W'(1) : (code == 2'd1) ? ADDR_W'(2) : ADDR_W'(4);
    endfunction

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R2
    read_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_en) |=> mem_rd_en && (mem_addr == $past(mem_addr) + stride($past(mem_size))));

    // R2
    read_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_rd_en)) |=> !mem_rd_en);

    // R6
    op_mode_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode_reg) |=> !mem_rd_en ##1 done);

    // R8
    mem_mode_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !mode_reg) |=> mem_rd_en ##4 done);

endmodule

bind pwl_interp pwl_interp_chk #(.ADDR_W(ADDR_W)) u_pwl_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_reg(mode_reg),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_size(mem_size),
    .busy(busy), .done(done)
);

// File: tb/test_pwl_interp.sv
module test_pwl_interp;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mode_reg = 1'b0;
    logic        round_en = 1'b0;
    logic [1:0]  entry_size = 2'd0;
    logic [15:0] x_in = '0;
    logic [15:0] base_addr = '0;
    logic [31:0] entry_a = '0;
    logic [31:0] entry_b = '0;
    logic        mem_rd_en;
    logic [15:0] mem_addr;
    logic [1:0]  mem_size;
    logic [31:0] mem_rdata = '0;
    logic        busy;
    logic        done;
    logic [39:0] result;

    int checks = 0;
    int errors = 0;
    logic [7:0] mem [0:2047];

    always #2.5 clk = ~clk;

    pwl_interp i_pwl_interp (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_reg(mode_reg),
        .round_en(round_en), .entry_size(entry_size), .x_in(x_in),
        .base_addr(base_addr), .entry_a(entry_a), .entry_b(entry_b),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .result(result)
    );

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] trim(input logic [31:0] v, input logic [1:0] sz);
        return (sz == 2'd0) ? (v & 32'hFF) : (sz == 2'd1) ? (v & 32'hFFFF) : v;
    endfunction

    // big-endian entry assembled from the byte image
    function automatic logic [31:0] fetch(input logic [15:0] a, input logic [1:0] sz);
        logic [31:0] v = '0;
        for (int k = 0; k < nbytes(sz); k++) v = {v[23:0], mem[(int'(a) + k) % 2048]};
        return v;
    endfunction

    function automatic logic [39:0] model(input logic [31:0] lo, input logic [31:0] hi,
                                          input logic [7:0] f, input bit rnd);
        longint full = longint'(lo) * 256 + (longint'(hi) - longint'(lo)) * longint'(f);
        return rnd ? 40'((full + 128) >>> 8) : 40'(full);
    endfunction

    // memory model: one-cycle latency, random junk above the entry
    always @(posedge clk) begin
        if (mem_rd_en)
            mem_rdata <= fetch(mem_addr, mem_size) |
                         (~trim(32'hFFFFFFFF, mem_size) & $urandom);
    end

    task automatic check(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run(input bit regm, input bit rnd, input logic [1:0] sz, input logic [15:0] x,
                       input logic [15:0] base, input logic [31:0] a, input logic [31:0] b,
                       input bit disturb);
        logic [31:0] lo, hi;
        logic [15:0] a0;
        logic [39:0] exp, held;
        logic [15:0] rd_addr [2];
        int nrd = 0;
        int cyc = 0;
        string tag;
        a0 = base + 16'(int'(x[15:8]) * nbytes(sz));
        if (regm) begin
            lo = trim(a, sz); hi = trim(b, sz);
        end else begin
            lo = fetch(a0, sz); hi = fetch(a0 + 16'(nbytes(sz)), sz);
        end
        exp = model(lo, hi, x[7:0], rnd);
        if (x[7:0] == 0) tag = "R5";
        else if (regm) tag = "R6";
        else if (sz != 2'd2) tag = "R7";
        else tag = rnd ? "R3" : "R4";
        @(negedge clk);
        start = 1'b1; mode_reg = regm; round_en = rnd; entry_size = sz;
        x_in = x; base_addr = base; entry_a = a; entry_b = b;
        do begin
            @(negedge clk);
            cyc++;
            if (disturb && cyc == 1) begin
                start = 1'b1; mode_reg = ~regm; round_en = ~rnd;
                entry_size = 2'(($urandom % 3)); x_in = 16'($urandom);
                base_addr = 16'($urandom % 900); entry_a = $urandom; entry_b = $urandom;
            end else begin
                start = 1'b0;
            end
            if (mem_rd_en) begin
                if (nrd < 2) rd_addr[nrd] = mem_addr;
                nrd++;
            end
        end while (!done && cyc < 20);
        start = 1'b0;
        check(cyc == (regm ? 2 : 5), disturb ? "R10" : "R8", 40'(cyc), regm ? 40'd2 : 40'd5);
        check(result == exp, disturb ? "R9" : tag, result, exp);
        if (regm) begin
            check(nrd == 0, "R6", 40'(nrd), 40'd0);
        end else begin
            check(nrd == 2, "R2", 40'(nrd), 40'd2);
            if (nrd == 2) begin
                check(rd_addr[0] == a0, "R2", 40'(rd_addr[0]), 40'(a0));
                check(rd_addr[1] == a0 + 16'(nbytes(sz)), "R2", 40'(rd_addr[1]),
                      40'(a0 + 16'(nbytes(sz))));
            end
        end
        held = result;
        @(negedge clk);
        check(!done, "R8", 40'(done), 40'd0);
        check(result == held, "R9", result, held);
    endtask

    // watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 2048; i++) mem[i] = 8'($urandom);
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !done && !mem_rd_en && result == 0, "R1", result, 40'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !mem_rd_en && result == 0, "R1", {busy, done, mem_rd_en}, 40'd0);

        // directed corner cases
        run(1, 1, 2'd0, 16'h0080, 16'h0, 32'h0, 32'h1, 0);               // R3 half up
        run(1, 1, 2'd0, 16'h0080, 16'h0, 32'h1, 32'h0, 0);               // R3 half on falling slope
        run(1, 0, 2'd2, 16'h00FF, 16'h0, 32'hFFFFFFFF, 32'h0, 0);       // R4 largest drop
        run(1, 1, 2'd2, 16'h00FF, 16'h0, 32'hFFFFFFFF, 32'h0, 0);       // R3 largest drop
        run(1, 1, 2'd1, 16'h0500, 16'h0, 32'hABCD1234, 32'h5555, 0);    // R5 rounded
        run(1, 0, 2'd0, 16'h0300, 16'h0, 32'hFFFFFF9C, 32'h12, 0);      // R5 unrounded, R7 junk
        run(0, 1, 2'd2, 16'hFF00, 16'd1000, 32'h0, 32'h0, 0);           // R5 top index
        run(0, 0, 2'd1, 16'h10C3, 16'd7, 32'h0, 32'h0, 0);              // R4 word
        run(0, 1, 2'd0, 16'h2A40, 16'd300, 32'h0, 32'h0, 1);            // R9 R10 disturbed
        run(1, 0, 2'd1, 16'h0177, 16'h0, 32'h0000FFFF, 32'h00000000, 1); // R9 R10 disturbed

        // constrained random jobs
        for (int n = 0; n < 400; n++) begin
            run(bit'($urandom % 2), bit'($urandom % 2), 2'($urandom % 3), 16'($urandom),
                16'($urandom % 1000), $urandom, $urandom, ($urandom % 8) == 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule